// File: doc/BRIEF.md
# GPIO Port Edge Interrupt Unit

This block raises interrupts from general-purpose input pins grouped in ports of eight. Each pin is first brought into the clock domain. It is then watched for one edge polarity, either rising or falling, chosen by a per-pin bit. A detected edge sets a sticky event bit. Software clears that bit by writing a one to it. Each port has its own interrupt line, which is high while any pin has both its event bit and its enable bit set.

A test register can inject events without any pin activity. While one of its bits is set, the matching event bit is set again on every cycle. Detection of both edges is not provided in hardware. Software gets that behaviour by flipping the pin's polarity bit after each event it services. A polarity change never produces an event by itself.

All registers sit in a flat address space with one window per port. A write strobe, an address and write data set the registers. Read data is a combinational function of the address.

Top module: `gpio_irq_top`

## Requirements
- R1: After a synchronous reset, every register reads zero and every interrupt output is low.
- R2: A pin whose polarity bit is 1 sets its event bit on a rising edge. A pin input that changes just before clock edge k is readable as an event after clock edge k+2, and not before.
- R3: A pin whose polarity bit is 0 sets its event bit on a falling edge. A rising edge on that pin leaves its event bit at 0.
- R4: Event bits latch whether or not the pin is enabled. A port's interrupt stays low while its enable register is zero.
- R5: The interrupt of port p is high exactly when some pin of port p has both its event bit and its enable bit set. Activity on one port does not touch another port's events or interrupt.
- R6: Writing the event register clears the bits written as 1 and leaves the bits written as 0 unchanged.
- R7: If an edge is detected in the same cycle as a clearing write to that bit, the event bit stays set.
- R8: A 1 in the force register sets the matching event bit on every cycle, including a cycle in which that bit is being cleared. Writing zero to the force register stops the injection, and the event bit can then be cleared.
- R9: Writing the polarity register while the pins are stable creates no event. The new polarity governs detection from the following cycle onward.
- R10: Port p's registers sit at p*0x30 plus these offsets: 0x14 event, 0x18 enable, 0x1C force, 0x20 polarity. Bit i of each register belongs to pin i. Any other address reads zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pinIn | input | NUM_PORTS*PINS | Asynchronous pin levels; bit p*PINS+i is pin i of port p |
| wrEn | input | 1 | Register write strobe |
| addr | input | ADDR_W | Register address, used for both reads and writes |
| wrData | input | DATA_W | Write data; only the low PINS bits are used |
| rdData | output | DATA_W | Register read data for `addr`, zero-extended |
| irqOut | output | NUM_PORTS | One interrupt line per port |

## Verification
Two functions can act on an event bit in the same cycle: edge detection setting it and a software write clearing it. A second case pairs the force register with such a clear. The bench counts the synchronizer stages and times a clearing write so that its capture edge is the same edge on which the detected rising edge is latched. It then reads the bit back and expects a one. The same readback is used with a force bit held while its event bit is written. A further clear, made after the pin has settled or the force has been removed, shows that the earlier survival came from the collision and not from a broken clear path.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register offsets inside one port window
  localparam int unsigned EVT_OFF = 32'h14;
  localparam int unsigned ENA_OFF = 32'h18;
  localparam int unsigned FRC_OFF = 32'h1C;
  localparam int unsigned POL_OFF = 32'h20;

  // Write strobes handed from control to datapath, one set per port
  typedef struct packed {
    logic evtClr;
    logic enaWr;
    logic frcWr;
    logic polWr;
  } portStrobeT;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_EVT,
    SEL_ENA,
    SEL_FRC,
    SEL_POL
  } rdSelT;

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int ADDR_W    = 8,
  parameter int STRIDE    = 48,
  parameter int PIDX_W    = 1
) (
  input  logic                            wrEn,
  input  logic [ADDR_W-1:0]               addr,
  output portStrobeT [NUM_PORTS-1:0]      strobe,
  output rdSelT                           rdSel,
  output logic [PIDX_W-1:0]               rdPort
);

  logic [NUM_PORTS-1:0] hitEvt;
  logic [NUM_PORTS-1:0] hitEna;
  logic [NUM_PORTS-1:0] hitFrc;
  logic [NUM_PORTS-1:0] hitPol;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
    localparam int unsigned BASE = p * STRIDE;
    assign hitEvt[p] = (addr == ADDR_W'(BASE + EVT_OFF));
    assign hitEna[p] = (addr == ADDR_W'(BASE + ENA_OFF));
    assign hitFrc[p] = (addr == ADDR_W'(BASE + FRC_OFF));
    assign hitPol[p] = (addr == ADDR_W'(BASE + POL_OFF));

    assign strobe[p].evtClr = wrEn & hitEvt[p];
    assign strobe[p].enaWr  = wrEn & hitEna[p];
    assign strobe[p].frcWr  = wrEn & hitFrc[p];
    assign strobe[p].polWr  = wrEn & hitPol[p];
  end

  always_comb begin
    rdSel  = SEL_NONE;
    rdPort = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hitEvt[p]) begin
        rdSel  = SEL_EVT;
        rdPort = PIDX_W'(p);
      end else if (hitEna[p]) begin
        rdSel  = SEL_ENA;
        rdPort = PIDX_W'(p);
      end else if (hitFrc[p]) begin
        rdSel  = SEL_FRC;
        rdPort = PIDX_W'(p);
      end else if (hitPol[p]) begin
        rdSel  = SEL_POL;
        rdPort = PIDX_W'(p);
      end
    end
  end

endmodule

// File: rtl/gpio_irq_dpath.sv
module gpio_irq_dpath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PINS      = 8,
  parameter int DATA_W    = 32,
  parameter int PIDX_W    = 1
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [NUM_PORTS*PINS-1:0]       pinIn,
  input  portStrobeT [NUM_PORTS-1:0]      strobe,
  input  logic [PINS-1:0]                 wrBits,
  input  rdSelT                           rdSel,
  input  logic [PIDX_W-1:0]               rdPort,
  output logic [DATA_W-1:0]               rdData,
  output logic [NUM_PORTS-1:0]            irqOut,
  output logic [NUM_PORTS-1:0][PINS-1:0]  evtVec,
  output logic [NUM_PORTS-1:0][PINS-1:0]  enaVec,
  output logic [NUM_PORTS-1:0][PINS-1:0]  frcVec,
  output logic [NUM_PORTS-1:0][PINS-1:0]  polVec,
  output logic [NUM_PORTS-1:0][PINS-1:0]  hitVec
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic [PINS-1:0] pinSync;
    logic [PINS-1:0] pinPrev;
    logic [PINS-1:0] evtQ;
    logic [PINS-1:0] enaQ;
    logic [PINS-1:0] frcQ;
    logic [PINS-1:0] polQ;
    logic [PINS-1:0] riseDet;
    logic [PINS-1:0] fallDet;
    logic [PINS-1:0] edgeHit;
    logic [PINS-1:0] clrMask;

    gpio_irq_sync #(.WIDTH(PINS)) u_sync (
      .clk (clk),
      .rst (rst),
      .din (pinIn[p*PINS +: PINS]),
      .dout(pinSync)
    );

    always_ff @(posedge clk) begin
      if (rst) pinPrev <= '0;
      else     pinPrev <= pinSync;
    end

    assign riseDet = pinSync & ~pinPrev;
    assign fallDet = ~pinSync & pinPrev;
    assign edgeHit = (polQ & riseDet) | (~polQ & fallDet);
    assign clrMask = strobe[p].evtClr ? wrBits : '0;

    // clear first, then edges and forced bits win
    always_ff @(posedge clk) begin
      if (rst) evtQ <= '0;
      else     evtQ <= (evtQ & ~clrMask) | edgeHit | frcQ;
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        enaQ <= '0;
        frcQ <= '0;
        polQ <= '0;
      end else begin
        if (strobe[p].enaWr) enaQ <= wrBits;
        if (strobe[p].frcWr) frcQ <= wrBits;
        if (strobe[p].polWr) polQ <= wrBits;
      end
    end

    assign irqOut[p] = |(evtQ & enaQ);
    assign evtVec[p] = evtQ;
    assign enaVec[p] = enaQ;
    assign frcVec[p] = frcQ;
    assign polVec[p] = polQ;
    assign hitVec[p] = edgeHit;
  end

  always_comb begin
    unique case (rdSel)
      SEL_EVT: rdData = DATA_W'(evtVec[rdPort]);
      SEL_ENA: rdData = DATA_W'(enaVec[rdPort]);
      SEL_FRC: rdData = DATA_W'(frcVec[rdPort]);
      SEL_POL: rdData = DATA_W'(polVec[rdPort]);
      default: rdData = '0;
    endcase
  end

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PINS      = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int STRIDE    = 48
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM_PORTS*PINS-1:0] pinIn,
  input  logic                      wrEn,
  input  logic [ADDR_W-1:0]         addr,
  input  logic [DATA_W-1:0]         wrData,
  output logic [DATA_W-1:0]         rdData,
  output logic [NUM_PORTS-1:0]      irqOut
);

  localparam int PIDX_W = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1;

  portStrobeT [NUM_PORTS-1:0]     strobe;
  rdSelT                          rdSel;
  logic [PIDX_W-1:0]              rdPort;
  logic [NUM_PORTS-1:0][PINS-1:0] evtVec;
  logic [NUM_PORTS-1:0][PINS-1:0] enaVec;
  logic [NUM_PORTS-1:0][PINS-1:0] frcVec;
  logic [NUM_PORTS-1:0][PINS-1:0] polVec;
  logic [NUM_PORTS-1:0][PINS-1:0] hitVec;
  logic                           unusedWrHi;

  assign unusedWrHi = ^wrData[DATA_W-1:PINS];

  gpio_irq_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .STRIDE   (STRIDE),
    .PIDX_W   (PIDX_W)
  ) u_ctrl (
    .wrEn  (wrEn),
    .addr  (addr),
    .strobe(strobe),
    .rdSel (rdSel),
    .rdPort(rdPort)
  );

  gpio_irq_dpath #(
    .NUM_PORTS(NUM_PORTS),
    .PINS     (PINS),
    .DATA_W   (DATA_W),
    .PIDX_W   (PIDX_W)
  ) u_dpath (
    .clk   (clk),
    .rst   (rst),
    .pinIn (pinIn),
    .strobe(strobe),
    .wrBits(wrData[PINS-1:0]),
    .rdSel (rdSel),
    .rdPort(rdPort),
    .rdData(rdData),
    .irqOut(irqOut),
    .evtVec(evtVec),
    .enaVec(enaVec),
    .frcVec(frcVec),
    .polVec(polVec),
    .hitVec(hitVec)
  );

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
  import gpio_irq_pkg::*;
#(
  parameter int NUM_PORTS = 2,
  parameter int PINS      = 8,
  parameter int ADDR_W    = 8,
  parameter int STRIDE    = 48
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wrEn,
  input logic [ADDR_W-1:0]              addr,
  input logic [PINS-1:0]                wrBits,
  input logic [NUM_PORTS-1:0]           irqOut,
  input logic [NUM_PORTS-1:0][PINS-1:0] evtVec,
  input logic [NUM_PORTS-1:0][PINS-1:0] enaVec,
  input logic [NUM_PORTS-1:0][PINS-1:0] frcVec,
  input logic [NUM_PORTS-1:0][PINS-1:0] hitVec
);

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
    localparam logic [ADDR_W-1:0] EVT_ADDR = ADDR_W'(p * STRIDE + EVT_OFF);

    // R8
    frc_sets_evt_chk: assert property (@(posedge clk) disable iff (rst)
      (frcVec[p] != '0) |=> ((evtVec[p] & $past(frcVec[p])) == $past(frcVec[p])));

    // R7
    edge_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (hitVec[p] != '0) |=> ((evtVec[p] & $past(hitVec[p])) == $past(hitVec[p])));

    // R6
    clr_evt_chk: assert property (@(posedge clk) disable iff (rst)
      (wrEn && addr == EVT_ADDR && (hitVec[p] | frcVec[p]) == '0)
        |=> ((evtVec[p] & $past(wrBits)) == '0));

    // R9
    evt_source_chk: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> ((evtVec[p] & ~$past(evtVec[p]) & ~$past(hitVec[p] | frcVec[p])) == '0));

    // R4
    irq_masked_chk: assert property (@(posedge clk) disable iff (rst)
      (enaVec[p] == '0) |-> !irqOut[p]);
  end

endmodule

bind gpio_irq_top gpio_irq_chk #(
  .NUM_PORTS(NUM_PORTS),
  .PINS     (PINS),
  .ADDR_W   (ADDR_W),
  .STRIDE   (STRIDE)
) u_chk (
  .clk   (clk),
  .rst   (rst),
  .wrEn  (wrEn),
  .addr  (addr),
  .wrBits(wrData[PINS-1:0]),
  .irqOut(irqOut),
  .evtVec(evtVec),
  .enaVec(enaVec),
  .frcVec(frcVec),
  .hitVec(hitVec)
);

// File: tb/gpio_irq_top_tb.sv
`timescale 1ns/1ps
module gpio_irq_top_tb;

  localparam int NP = 2;
  localparam int PN = 8;
  localparam int AW = 8;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NP*PN-1:0] pinIn = '0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] rdData;
  logic [NP-1:0] irqOut;

  typedef struct {
    string       req;
    int          kind;   // 0 register read, 1 interrupt vector
    logic [31:0] exp;
  } itemT;

  itemT queueQ[$];
  event sampleEv;
  int   total = 0;
  int   bad   = 0;
  bit   finished = 0;

  always #10 clk = ~clk;

  gpio_irq_top #(.NUM_PORTS(NP), .PINS(PN), .ADDR_W(AW), .DATA_W(DW), .STRIDE(48)) u_dut (
    .clk(clk), .rst(rst), .pinIn(pinIn), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irqOut(irqOut)
  );

  // monitor: pops expectations and compares
  initial begin
    forever begin
      @(sampleEv);
      #1;
      begin
        itemT it;
        logic [31:0] act;
        it  = queueQ.pop_front();
        act = (it.kind == 0) ? rdData : 32'(irqOut);
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s: actual=%h expected=%h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  // called at a negedge; returns at the negedge after the capture edge
  task automatic regWrite(int a, int d);
    wrEn = 1'b1; addr = AW'(a); wrData = DW'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic expReg(string req, int a, int e);
    itemT it;
    addr = AW'(a);
    it.req = req; it.kind = 0; it.exp = 32'(e);
    queueQ.push_back(it);
    -> sampleEv;
    #2;
  endtask

  task automatic expIrq(string req, int e);
    itemT it;
    it.req = req; it.kind = 1; it.exp = 32'(e);
    queueQ.push_back(it);
    -> sampleEv;
    #2;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    waitCyc(3);
    rst = 1'b0;
    waitCyc(1);
    // R1 reset state
    expReg("R1 evt0", 8'h14, 0);
    expReg("R1 ena0", 8'h18, 0);
    expReg("R1 frc0", 8'h1C, 0);
    expReg("R1 pol1", 8'h50, 0);
    expIrq("R1 irq", 0);

    // R2 rising on pin0, R3 rising ignored on pin1
    regWrite(8'h20, 8'h01);
    pinIn[0] = 1'b1; pinIn[1] = 1'b1;
    waitCyc(2);
    expReg("R2 latency", 8'h14, 0);
    waitCyc(1);
    expReg("R2 R3 rise", 8'h14, 8'h01);
    expIrq("R4 disabled", 0);

    // R3 falling on pin1
    pinIn[1] = 1'b0;
    waitCyc(3);
    expReg("R3 fall", 8'h14, 8'h03);

    // R4 / R5 enable masking
    regWrite(8'h18, 8'h02);
    expIrq("R4 enabled", 2'b01);
    regWrite(8'h18, 8'h04);
    expIrq("R5 masked", 2'b00);

    // R6 selective clear
    regWrite(8'h14, 8'h01);
    expReg("R6 partial", 8'h14, 8'h02);
    regWrite(8'h14, 8'h02);
    expReg("R6 rest", 8'h14, 0);

    // R9 polarity change with stable pins
    regWrite(8'h20, 8'hFF);
    waitCyc(4);
    expReg("R9 no event", 8'h14, 0);
    pinIn[2] = 1'b1;
    waitCyc(3);
    expReg("R9 new pol", 8'h14, 8'h04);
    regWrite(8'h14, 8'h04);
    expReg("R6 clr pin2", 8'h14, 0);

    // R7 edge and clear in the same cycle
    pinIn[3] = 1'b1;
    waitCyc(2);
    regWrite(8'h14, 8'h08);
    expReg("R7 collision", 8'h14, 8'h08);
    regWrite(8'h14, 8'h08);
    expReg("R7 later clr", 8'h14, 0);

    // R8 force on port1 pin7
    regWrite(8'h4C, 8'h80);
    waitCyc(1);
    expReg("R8 forced", 8'h44, 8'h80);
    regWrite(8'h44, 8'h80);
    expReg("R8 clr blocked", 8'h44, 8'h80);
    regWrite(8'h4C, 0);
    regWrite(8'h44, 8'h80);
    expReg("R8 released", 8'h44, 0);
    expReg("R8 frc zero", 8'h4C, 0);

    // R5 port independence
    regWrite(8'h50, 8'h80);
    regWrite(8'h48, 8'h80);
    expIrq("R5 idle", 0);
    pinIn[15] = 1'b1;
    waitCyc(3);
    expIrq("R5 port1 only", 2'b10);
    expReg("R5 port0 untouched", 8'h14, 0);

    // R10 address map
    regWrite(8'h24, 8'hFF);
    expReg("R10 hole", 8'h24, 0);
    expReg("R10 port1 evt", 8'h44, 8'h80);
    regWrite(8'h10, 8'hFF);
    expReg("R10 ena0 kept", 8'h18, 8'h04);
    expReg("R10 pol0 kept", 8'h20, 8'hFF);
    expReg("R10 pol1", 8'h50, 8'h80);

    waitCyc(2);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule